// File: doc/BRIEF.md
# Asynchronous SRAM Write/Read Timing Monitor

This block is a passive observer for a byte-lane asynchronous static RAM. It does not drive the bus and holds no data. The control, address and data pins are captured on a fast reference clock, and the monitor rebuilds the effective write window from those samples. The window is open only while four enables agree, and the enables have mixed polarity. For every window the monitor measures its length, the spacing between window openings, how long the address and the data were steady before the window closed, and whether the RAM drove the data bus during a window that should have held its outputs in high impedance.

Any of the four enables can open or close a window, so every timing rule is checked against the edge that actually closed it. Each rule has its own one-cycle pulse output and its own sticky flag, which only reset clears. The monitor also counts completed writes and reports a 2-bit code for the signal that started and the signal that ended each window. All times are in reference-clock ticks, and each minimum is a parameter.

Top module: `sram_tmon`

## Requirements
- R1: A write window is open in a sample exactly when `strobe_n`=0, `sel_lo_n`=0, `sel_hi`=1 and at least one bit of `lane_n` is 0. `wr_count` increments by one, and `wr_done` pulses, in the sample where an open window closes. A window that is never opened leaves the count unchanged.
- R2: At each close, `end_src` reports the signal that deactivated: 0 = write strobe, 1 = byte lanes (all high), 2 = low-active select, 3 = high-active select. When several deactivate in the same sample, the lowest code wins.
- R3: At each open, `start_src` reports the signal that activated, using the same codes and the same lowest-code-wins priority.
- R4: Bit 0 (width) of `viol_pulse` fires at a close when the window was open for fewer than `T_WP` samples. Exactly `T_WP` samples is legal.
- R5: Bit 1 (period) fires at an open when fewer than `T_WC` samples have passed since the previous open. The first window after reset is never flagged, and exactly `T_WC` is legal.
- R6: Bit 2 (address move) fires in any sample where the window was open in both this sample and the previous one and the address differs from the previous sample.
- R7: Bit 3 (address setup) fires at a close when the address was unchanged for fewer than `T_AS` consecutive samples up to and including the last open sample. Exactly `T_AS` is legal.
- R8: Bit 4 (data setup) fires at a close when `dq` was unchanged for fewer than `T_DS` consecutive samples up to and including the last open sample. A data change in the closing sample or later is not flagged, since hold time is zero.
- R9: Bit 5 (contention) fires in any open sample where `ram_drive`=1 and the window opened without the write strobe being its only late enable. That is, some other enable became active in the same sample as the strobe fell or after it. `ram_drive` has no effect outside a window or in a window the strobe opened last.
- R10: Each `viol_pulse` bit lasts one sample and also sets the matching `viol_sticky` bit. A sticky bit stays set until reset. Reset clears all flags, pulses, codes and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Sampled write strobe, low active |
| sel_lo_n | input | 1 | Sampled select, low active |
| sel_hi | input | 1 | Sampled select, high active |
| lane_n | input | NB | Sampled byte-lane enables, low active |
| addr | input | AW | Sampled address pins |
| dq | input | DW | Sampled data pins |
| ram_drive | input | 1 | High when the RAM drives the data pins |
| viol_pulse | output | 6 | One-sample violation pulses: 0 width, 1 period, 2 address move, 3 address setup, 4 data setup, 5 contention |
| viol_sticky | output | 6 | Sticky copies of the pulses |
| wr_done | output | 1 | Pulses in the sample a window closes |
| wr_count | output | CNTW | Completed write windows |
| start_src | output | 2 | Code of the signal that opened the latest window |
| end_src | output | 2 | Code of the signal that closed the latest window |

## Verification
The bench drives each of the four enables in turn as the opener and as the closer, and it puts every minimum exactly on its boundary and one tick under it. An off-by-one counter would flag the legal case or miss the short one. Simultaneous opening and closing edges check the priority order and the rule that a strobe falling together with a select still counts as early. A design that only looks at strobe edges would report the wrong code there or would miss the contention. A data change during the window right before the close must be caught. An address change during the window must also raise a setup breach. Near-miss patterns with one enable missing check that nothing is counted.

// File: rtl/sram_tmon_pkg.sv
package sram_tmon_pkg;

  typedef enum logic [1:0] {
    SRC_STROBE = 2'd0,
    SRC_LANE   = 2'd1,
    SRC_SELLO  = 2'd2,
    SRC_SELHI  = 2'd3
  } src_e;

  typedef struct packed {
    logic strobe_n;
    logic sel_lo_n;
    logic sel_hi;
  } ctl_t;

  localparam int NRULE       = 6;
  localparam int RU_WIDTH    = 0;
  localparam int RU_PERIOD   = 1;
  localparam int RU_AMOVE    = 2;
  localparam int RU_ASETUP   = 3;
  localparam int RU_DSETUP   = 4;
  localparam int RU_CONTEND  = 5;

endpackage

// File: rtl/tmon_win_decode.sv
module tmon_win_decode
  import sram_tmon_pkg::*;
#(
  parameter int NB = 2
) (
  input  ctl_t          cur,
  input  logic [NB-1:0] cur_lane_n,
  input  ctl_t          prv,
  input  logic [NB-1:0] prv_lane_n,
  output logic          win_now,
  output logic          win_prev,
  output logic          opened,
  output logic          closed,
  output logic          early,
  output src_e          src_open,
  output src_e          src_close
);

  logic cur_lane_any, prv_lane_any;
  logic prv_others;

  assign cur_lane_any = ~&cur_lane_n;
  assign prv_lane_any = ~&prv_lane_n;

  assign win_now  = ~cur.strobe_n & ~cur.sel_lo_n & cur.sel_hi & cur_lane_any;
  assign win_prev = ~prv.strobe_n & ~prv.sel_lo_n & prv.sel_hi & prv_lane_any;
  assign opened   = win_now & ~win_prev;
  assign closed   = win_prev & ~win_now;

  // all non-strobe enables already active one sample earlier -> strobe opened last
  assign prv_others = ~prv.sel_lo_n & prv.sel_hi & prv_lane_any;
  assign early      = ~prv_others;

  always_comb begin
    if (prv.strobe_n && !cur.strobe_n)       src_open = SRC_STROBE;
    else if (!prv_lane_any && cur_lane_any)  src_open = SRC_LANE;
    else if (prv.sel_lo_n && !cur.sel_lo_n)  src_open = SRC_SELLO;
    else                                     src_open = SRC_SELHI;
  end

  always_comb begin
    if (cur.strobe_n)                        src_close = SRC_STROBE;
    else if (!cur_lane_any)                  src_close = SRC_LANE;
    else if (cur.sel_lo_n)                   src_close = SRC_SELLO;
    else                                     src_close = SRC_SELHI;
  end

endmodule

// File: rtl/tmon_stable_ctr.sv
module tmon_stable_ctr #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  val,
  output logic          moved,
  output logic [CW-1:0] run_q
);

  logic [W-1:0] last_q;

  assign moved = (val != last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      run_q  <= '0;
    end else begin
      last_q <= val;
      if (moved)             run_q <= CW'(1);
      else if (run_q != '1)  run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmon_flag_bank.sv
module tmon_flag_bank #(
  parameter int NR = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NR-1:0] hit,
  output logic [NR-1:0] pulse_q,
  output logic [NR-1:0] sticky_q
);

  for (genvar i = 0; i < NR; i++) begin : g_rule
    always_ff @(posedge clk) begin
      if (rst) begin
        pulse_q[i]  <= 1'b0;
        sticky_q[i] <= 1'b0;
      end else begin
        pulse_q[i]  <= hit[i];
        sticky_q[i] <= sticky_q[i] | hit[i];
      end
    end
  end

endmodule

// File: rtl/sram_tmon.sv
module sram_tmon
  import sram_tmon_pkg::*;
#(
  parameter int AW   = 19,
  parameter int DW   = 16,
  parameter int NB   = 2,
  parameter int T_WP = 15,
  parameter int T_WC = 22,
  parameter int T_AS = 18,
  parameter int T_DS = 9,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe_n,
  input  logic            sel_lo_n,
  input  logic            sel_hi,
  input  logic [NB-1:0]   lane_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   dq,
  input  logic            ram_drive,
  output logic [5:0]      viol_pulse,
  output logic [5:0]      viol_sticky,
  output logic            wr_done,
  output logic [CNTW-1:0] wr_count,
  output logic [1:0]      start_src,
  output logic [1:0]      end_src
);

  localparam int MAX_AB = (T_WP > T_WC) ? T_WP : T_WC;
  localparam int MAX_CD = (T_AS > T_DS) ? T_AS : T_DS;
  localparam int MAXT   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXT + 1) + 1;
  localparam logic [CW-1:0] LIM_WP = CW'(T_WP);
  localparam logic [CW-1:0] LIM_WC = CW'(T_WC);
  localparam logic [CW-1:0] LIM_AS = CW'(T_AS);
  localparam logic [CW-1:0] LIM_DS = CW'(T_DS);

  ctl_t          cur, prv_q;
  logic [NB-1:0] lane_prv_q;

  assign cur = '{strobe_n: strobe_n, sel_lo_n: sel_lo_n, sel_hi: sel_hi};

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_q      <= '{strobe_n: 1'b1, sel_lo_n: 1'b1, sel_hi: 1'b0};
      lane_prv_q <= '1;
    end else begin
      prv_q      <= cur;
      lane_prv_q <= lane_n;
    end
  end

  logic win_now, win_prev, opened, closed, early;
  src_e src_open, src_close;

  tmon_win_decode #(.NB(NB)) u_dec (
    .cur        (cur),
    .cur_lane_n (lane_n),
    .prv        (prv_q),
    .prv_lane_n (lane_prv_q),
    .win_now    (win_now),
    .win_prev   (win_prev),
    .opened     (opened),
    .closed     (closed),
    .early      (early),
    .src_open   (src_open),
    .src_close  (src_close)
  );

  logic          a_moved, d_moved;
  logic [CW-1:0] a_run_q, d_run_q;

  tmon_stable_ctr #(.W(AW), .CW(CW)) u_arun (
    .clk (clk), .rst (rst), .val (addr), .moved (a_moved), .run_q (a_run_q)
  );

  tmon_stable_ctr #(.W(DW), .CW(CW)) u_drun (
    .clk (clk), .rst (rst), .val (dq), .moved (d_moved), .run_q (d_run_q)
  );

  // window length, distance between openings, early-open memory
  logic [CW-1:0] open_len_q, since_q;
  logic          seen_q, early_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_len_q <= '0;
      since_q    <= '0;
      seen_q     <= 1'b0;
      early_q    <= 1'b0;
    end else begin
      if (opened)                               open_len_q <= CW'(1);
      else if (win_now && open_len_q != '1)     open_len_q <= open_len_q + 1'b1;

      if (opened)                               since_q <= CW'(1);
      else if (since_q != '1)                   since_q <= since_q + 1'b1;

      if (opened) begin
        seen_q  <= 1'b1;
        early_q <= early;
      end
    end
  end

  logic [NRULE-1:0] hit;
  logic             early_eff;

  assign early_eff = opened ? early : early_q;

  always_comb begin
    hit             = '0;
    hit[RU_WIDTH]   = closed && (open_len_q < LIM_WP);
    hit[RU_PERIOD]  = opened && seen_q && (since_q < LIM_WC);
    hit[RU_AMOVE]   = win_now && win_prev && a_moved;
    hit[RU_ASETUP]  = closed && (a_run_q < LIM_AS);
    hit[RU_DSETUP]  = closed && (d_run_q < LIM_DS);
    hit[RU_CONTEND] = win_now && early_eff && ram_drive;
  end

  tmon_flag_bank #(.NR(NRULE)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .pulse_q  (viol_pulse),
    .sticky_q (viol_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_done   <= 1'b0;
      wr_count  <= '0;
      start_src <= 2'd0;
      end_src   <= 2'd0;
    end else begin
      wr_done <= closed;
      if (closed) begin
        wr_count <= wr_count + 1'b1;
        end_src  <= src_close;
      end
      if (opened) start_src <= src_open;
    end
  end

  // d_moved is consumed through d_run_q; keep the net read for lint
  logic unused_ok;
  assign unused_ok = d_moved;

endmodule

// File: rtl/sram_tmon_chk.sv
module sram_tmon_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_done,
  input logic [CNTW-1:0] wr_count,
  input logic [1:0]      end_src,
  input logic [5:0]      viol_pulse,
  input logic [5:0]      viol_sticky
);

  p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !$past(rst)) |-> $stable(wr_count));

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !$past(rst)) |-> (wr_count == $past(wr_count) + CNTW'(1)));

  p_end_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !$past(rst)) |-> $stable(end_src));

  p_width_at_close_r4: assert property (@(posedge clk) disable iff (rst)
    viol_pulse[0] |-> wr_done);

  p_asetup_at_close_r7: assert property (@(posedge clk) disable iff (rst)
    viol_pulse[3] |-> wr_done);

  p_dsetup_at_close_r8: assert property (@(posedge clk) disable iff (rst)
    viol_pulse[4] |-> wr_done);

  p_sticky_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

  p_pulse_sets_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (|viol_pulse) |-> ((viol_sticky & viol_pulse) == viol_pulse));

endmodule

bind sram_tmon sram_tmon_chk #(.CNTW(CNTW)) u_chk (.*);

// File: tb/sim_sram_tmon.sv
module sim_sram_tmon;

  localparam int AW = 19, DW = 16, NB = 2, CNTW = 16;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] cl;
    logic [1:0] lanes;
    logic [7:0] pre;
    logic [7:0] wlen;
    logic [7:0] dmove;
    logic [7:0] amove;
    logic       drv;
    logic [7:0] gap;
    logic [5:0] mask;
  } vec_t;

  // op/cl codes: 0 strobe, 1 lanes, 2 low select, 3 high select
  // mask bits: 0 width, 1 period, 2 addr move, 3 addr setup, 4 data setup, 5 contention
  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{2'd0, 2'd0, 2'd3,  8'd5, 8'd16, 8'd0,  8'd0,  1'b0, 8'd10, 6'd0 },
    '{2'd1, 2'd1, 2'd1,  8'd5, 8'd15, 8'd0,  8'd0,  1'b0, 8'd10, 6'd0 },
    '{2'd2, 2'd2, 2'd2,  8'd6, 8'd14, 8'd0,  8'd0,  1'b0, 8'd10, 6'd1 },
    '{2'd3, 2'd3, 2'd3,  8'd2, 8'd15, 8'd0,  8'd0,  1'b0, 8'd10, 6'd8 },
    '{2'd0, 2'd1, 2'd3,  8'd3, 8'd15, 8'd0,  8'd0,  1'b0, 8'd10, 6'd0 },
    '{2'd1, 2'd0, 2'd3,  8'd5, 8'd16, 8'd8,  8'd0,  1'b0, 8'd10, 6'd16},
    '{2'd2, 2'd3, 2'd3,  8'd5, 8'd16, 8'd7,  8'd0,  1'b0, 8'd10, 6'd0 },
    '{2'd3, 2'd2, 2'd3,  8'd5, 8'd16, 8'd0,  8'd0,  1'b1, 8'd10, 6'd32},
    '{2'd0, 2'd0, 2'd3,  8'd5, 8'd16, 8'd0,  8'd0,  1'b1, 8'd0,  6'd0 },
    '{2'd0, 2'd0, 2'd3,  8'd3, 8'd16, 8'd0,  8'd0,  1'b0, 8'd0,  6'd2 },
    '{2'd0, 2'd0, 2'd3,  8'd4, 8'd16, 8'd0,  8'd0,  1'b0, 8'd10, 6'd0 },
    '{2'd1, 2'd1, 2'd1,  8'd1, 8'd10, 8'd5,  8'd0,  1'b1, 8'd10, 6'd57},
    '{2'd0, 2'd0, 2'd3,  8'd20, 8'd20, 8'd0, 8'd10, 1'b0, 8'd10, 6'd12}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_n = 1'b1, sel_lo_n = 1'b1, sel_hi = 1'b0;
  logic [NB-1:0] lane_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq = '0;
  logic ram_drive = 1'b0;

  logic [5:0]      viol_pulse, viol_sticky;
  logic            wr_done;
  logic [CNTW-1:0] wr_count;
  logic [1:0]      start_src, end_src;

  always #2 clk = ~clk;

  sram_tmon #(.AW(AW), .DW(DW), .NB(NB), .T_WP(15), .T_WC(22), .T_AS(18), .T_DS(9), .CNTW(CNTW)) u0 (
    .clk (clk), .rst (rst), .strobe_n (strobe_n), .sel_lo_n (sel_lo_n), .sel_hi (sel_hi),
    .lane_n (lane_n), .addr (addr), .dq (dq), .ram_drive (ram_drive),
    .viol_pulse (viol_pulse), .viol_sticky (viol_sticky), .wr_done (wr_done),
    .wr_count (wr_count), .start_src (start_src), .end_src (end_src)
  );

  int n_chk = 0, n_err = 0;
  logic finished = 1'b0;
  logic [5:0] acc;
  int n_done;
  logic [1:0] got_start, got_end;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    acc = acc | viol_pulse;
    if (wr_done) begin
      n_done++;
      got_start = start_src;
      got_end   = end_src;
    end
  endtask

  task automatic set_sig(input int idx, input logic act, input logic [1:0] lanes);
    case (idx)
      0: strobe_n = ~act;
      1: lane_n   = act ? ~lanes : 2'b11;
      2: sel_lo_n = ~act;
      3: sel_hi   = act;
      default: ;
    endcase
  endtask

  task automatic run_write(input int op, input int op2, input int cl, input int cl2,
                           input logic [1:0] lanes, input int pre, input int wlen,
                           input int dmove, input int amove, input logic drv,
                           input int gap, input int idx);
    acc = '0; n_done = 0;
    for (int s = 0; s < 4; s++)
      if (s != op && s != op2) set_sig(s, 1'b1, lanes);
    addr = AW'(32'h100 + idx * 7);
    dq   = DW'(32'hA000 + idx * 3);
    for (int k = 0; k < pre; k++) step();
    set_sig(op, 1'b1, lanes);
    set_sig(op2, 1'b1, lanes);
    ram_drive = drv;
    for (int k = 0; k < wlen; k++) begin
      if (dmove != 0 && k == dmove) dq = ~dq;
      if (amove != 0 && k == amove) addr = addr ^ AW'(1);
      step();
    end
    set_sig(cl, 1'b0, lanes);
    set_sig(cl2, 1'b0, lanes);
    ram_drive = 1'b0;
    step();
    for (int s = 0; s < 4; s++) set_sig(s, 1'b0, lanes);
    step();
    for (int k = 0; k < gap; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state
    chk("R10 reset sticky", viol_sticky == 6'd0, viol_sticky, 0);
    chk("R10 reset pulse", viol_pulse == 6'd0, viol_pulse, 0);
    chk("R1 reset count", wr_count == 0, wr_count, 0);

    // R1/R9 near misses: one enable missing, RAM driving, address toggling
    acc = '0; n_done = 0;
    strobe_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1; lane_n = 2'b11; ram_drive = 1'b1;
    for (int k = 0; k < 12; k++) begin addr = AW'(k); step(); end
    lane_n = 2'b10; sel_hi = 1'b0;
    for (int k = 0; k < 12; k++) begin dq = DW'(k); step(); end
    strobe_n = 1'b1; sel_lo_n = 1'b1; lane_n = 2'b11; ram_drive = 1'b0;
    step(); step();
    chk("R1 no window no count", wr_count == 0 && n_done == 0, wr_count, 0);
    chk("R9 drive outside window ignored", acc == 6'd0, acc, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      cnt0 = int'(wr_count);
      run_write(VT[i].op, 4, VT[i].cl, 4, VT[i].lanes, VT[i].pre, VT[i].wlen,
                VT[i].dmove, VT[i].amove, VT[i].drv, VT[i].gap, i + 1);
      chk($sformatf("R4-R9 flags vec %0d (R4 R5 R6 R7 R8 R9)", i), acc == VT[i].mask, acc, VT[i].mask);
      chk($sformatf("R1 done once vec %0d", i), n_done == 1, n_done, 1);
      chk($sformatf("R1 count vec %0d", i), int'(wr_count) == cnt0 + 1, wr_count, cnt0 + 1);
      chk($sformatf("R2 end code vec %0d", i), got_end == VT[i].cl, got_end, VT[i].cl);
      chk($sformatf("R3 start code vec %0d", i), got_start == VT[i].op, got_start, VT[i].op);
    end

    // simultaneous open of strobe and high select: code 0, counts as early (R3, R9)
    run_write(0, 3, 2, 3, 2'b11, 5, 16, 0, 0, 1'b1, 10, 20);
    chk("R3 simultaneous open priority", got_start == 2'd0, got_start, 0);
    chk("R2 simultaneous close priority sel", got_end == 2'd2, got_end, 2);
    chk("R9 simultaneous strobe is early", acc == 6'd32, acc, 32);

    // simultaneous lanes + low select open; strobe + lanes close
    run_write(1, 2, 0, 1, 2'b10, 5, 16, 0, 0, 1'b0, 10, 21);
    chk("R3 simultaneous open lanes first", got_start == 2'd1, got_start, 1);
    chk("R2 simultaneous close strobe first", got_end == 2'd0, got_end, 0);
    chk("R9 early without drive clean", acc == 6'd0, acc, 0);

    // R10 sticky accumulation and pulse width
    chk("R10 sticky holds all", viol_sticky == 6'h3F, viol_sticky, 63);
    chk("R10 pulses cleared", viol_pulse == 6'd0, viol_pulse, 0);
    chk("R1 total count", wr_count == CNTW'(NV + 2), wr_count, NV + 2);

    // R10 reset clears
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk("R10 reset clears sticky", viol_sticky == 6'd0, viol_sticky, 0);
    chk("R10 reset clears count", wr_count == 0, wr_count, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule